// File: doc/BRIEF.md
# Stepped Nibble-Entry Arithmetic Unit

This block is an 8-bit signed arithmetic unit operated from a small front panel. Its inputs are a 4-bit data input and one step input, which serves as the clock. Its output is an 8-bit value meant for a row of indicator lamps. Each rising edge of the step input moves the unit through one stage of a fixed nine-stage cycle. In that cycle the operator keys in two 8-bit operands one nibble at a time, can choose to negate each operand, and picks an operation code. The unit then shows the result.

The cycle has nine stages:

| Stage | Action |
|-------|--------|
| 1 | Capture the high nibble of operand A |
| 2 | Capture the low nibble of operand A |
| 3 | Negate operand A if requested |
| 4 | Show operand A on the output |
| 5 | Capture the opcode |
| 6 | Capture the high nibble of operand B |
| 7 | Capture the low nibble of operand B |
| 8 | Negate operand B if requested |
| 9 | Show the result |

After stage 9 the unit returns to stage 1. The unit supports addition, subtraction, multiplication and division. Both operands are treated as two's-complement values, and every result is cut to 8 bits.

Top module: `nibble_step_alu`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the unit at stage 1 and clears operand A, operand B, the opcode and the output to zero.
- R2: Each rising edge outside reset advances exactly one stage through stages 1 to 9 in order. The edge taken in stage 9 returns the unit to stage 1.
- R3: The edge in stage 1 loads `nib_in` into bits 7:4 of operand A, and the edge in stage 2 loads `nib_in` into bits 3:0. The edge in stage 4 puts operand A on `result_out`.
- R4: At the edges of stage 3 (operand A) and stage 8 (operand B), the operand is replaced by its two's-complement negation when `nib_in[2]` and `nib_in[1]` are both 1. For any other input the operand is left unchanged.
- R5: The edge in stage 5 captures all four bits of `nib_in` as the opcode. The edges in stages 6 and 7 load bits 7:4 and then bits 3:0 of operand B.
- R6: Opcode 4'b0000 gives A + B, cut to 8 bits.
- R7: Opcode 4'b0001 gives A - B, cut to 8 bits.
- R8: Opcode 4'b0010 gives the low 8 bits of A × B.
- R9: Opcode 4'b0011 gives the signed quotient A / B, rounded toward zero and cut to 8 bits. For example, -128 / -1 gives 8'h80.
- R10: Opcode 4'b0011 with B equal to zero gives 8'hFF.
- R11: Any opcode other than 4'b0000 to 4'b0011 gives a result of 8'h00.
- R12: The edge in stage 9 puts the result on `result_out`. `result_out` changes only at the edges of stages 4 and 9, or on reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Step input; each rising edge advances one stage |
| rst | input | 1 | Synchronous reset, active high |
| nib_in | input | 4 | Nibble, negate-request pattern or opcode, depending on the stage |
| result_out | output | 8 | Shows operand A after stage 4 and the result after stage 9 |

## Verification
The hardest case to reach is the pair of negation stages. Negation is visible only when a value reaches the output several edges later, so each negated operand has to come through an operation whose result exposes it. The stimulus therefore walks complete nine-stage sequences. The stage 3 and stage 8 inputs use both patterns that request negation and patterns with only one of the two bits set. The operands are chosen so that -128 / -1, a zero divisor and product wrap-around all appear. A reset dropped into the middle of a sequence, followed by a full sequence, shows that the stage count restarts at stage 1.

// File: rtl/nsa_pkg.sv
package nsa_pkg;

    // Stage numbers; the order is the behaviour of the block.
    localparam int STG_A_HI   = 1;
    localparam int STG_A_LO   = 2;
    localparam int STG_A_NEG  = 3;
    localparam int STG_SHOW_A = 4;
    localparam int STG_OPCODE = 5;
    localparam int STG_B_HI   = 6;
    localparam int STG_B_LO   = 7;
    localparam int STG_B_NEG  = 8;
    localparam int STG_SHOW_Y = 9;
    localparam int NUM_STAGES = 9;

    // Operation encodings.
    localparam int OP_ADD = 0;
    localparam int OP_SUB = 1;
    localparam int OP_MUL = 2;
    localparam int OP_DIV = 3;

    // Negation is requested when the two middle input bits are both set.
    function automatic logic neg_request(input logic bit2, input logic bit1);
        return bit2 & bit1;
    endfunction

endpackage

// File: rtl/nsa_stepper.sv
module nsa_stepper #(
    parameter int STAGES = 9,
    localparam int SW = $clog2(STAGES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [SW-1:0] stage_q
);

    logic [SW-1:0] stage_d;

    always_comb begin
        if (rst || stage_q == SW'(STAGES)) begin
            stage_d = SW'(1);
        end else begin
            stage_d = stage_q + SW'(1);
        end
    end

    always_ff @(posedge clk) begin
        stage_q <= stage_d;
    end

endmodule

// File: rtl/nsa_negate.sv
module nsa_negate #(
    parameter int DW = 8
) (
    input  logic          en,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] y
);

    always_comb begin
        y = en ? (~d + DW'(1)) : d;
    end

endmodule

// File: rtl/nsa_divider.sv
module nsa_divider #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic [DW-1:0] quotient
);

    logic          sign_n;
    logic          sign_d;
    logic          div_zero;
    logic [DW-1:0] mag_n;
    logic [DW-1:0] mag_d;
    logic [DW-1:0] safe_d;
    logic [DW-1:0] mag_q;

    always_comb begin
        sign_n   = dividend[DW-1];
        sign_d   = divisor[DW-1];
        div_zero = (divisor == '0);
        // Magnitudes as unsigned values: the most negative input maps to 2^(DW-1).
        mag_n    = sign_n ? (~dividend + DW'(1)) : dividend;
        mag_d    = sign_d ? (~divisor + DW'(1)) : divisor;
        safe_d   = div_zero ? DW'(1) : mag_d;
        mag_q    = mag_n / safe_d;
        if (div_zero) begin
            quotient = '1;
        end else if (sign_n ^ sign_d) begin
            quotient = ~mag_q + DW'(1);
        end else begin
            quotient = mag_q;
        end
    end

endmodule

// File: rtl/nsa_alu.sv
module nsa_alu
    import nsa_pkg::*;
#(
    parameter int DW = 8,
    parameter int OW = 4
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [OW-1:0] op,
    output logic [DW-1:0] y
);

    logic [DW-1:0] quo;

    nsa_divider #(.DW(DW)) u_div (
        .dividend (a),
        .divisor  (b),
        .quotient (quo)
    );

    always_comb begin
        case (op)
            OW'(OP_ADD): y = a + b;
            OW'(OP_SUB): y = a - b;
            OW'(OP_MUL): y = a * b;
            OW'(OP_DIV): y = quo;
            default:     y = '0;
        endcase
    end

endmodule

// File: rtl/nibble_step_alu.sv
module nibble_step_alu
    import nsa_pkg::*;
#(
    parameter int NW = 4,
    localparam int DW = 2 * NW,
    localparam int SW = $clog2(NUM_STAGES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NW-1:0] nib_in,
    output logic [DW-1:0] result_out
);

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [NW-1:0] op;
        logic [DW-1:0] shown;
    } regs_t;

    regs_t         r_d;
    regs_t         r_q;
    logic [SW-1:0] stage_q;
    logic [DW-1:0] a_q;
    logic [DW-1:0] b_q;
    logic [NW-1:0] op_q;
    logic [DW-1:0] a_neg;
    logic [DW-1:0] b_neg;
    logic [DW-1:0] alu_y;
    logic          neg_req;

    assign a_q        = r_q.a;
    assign b_q        = r_q.b;
    assign op_q       = r_q.op;
    assign result_out = r_q.shown;
    assign neg_req    = neg_request(nib_in[2], nib_in[1]);

    nsa_stepper #(.STAGES(NUM_STAGES)) u_step (
        .clk     (clk),
        .rst     (rst),
        .stage_q (stage_q)
    );

    nsa_negate #(.DW(DW)) u_neg_a (
        .en (neg_req),
        .d  (a_q),
        .y  (a_neg)
    );

    nsa_negate #(.DW(DW)) u_neg_b (
        .en (neg_req),
        .d  (b_q),
        .y  (b_neg)
    );

    nsa_alu #(.DW(DW), .OW(NW)) u_alu (
        .a  (a_q),
        .b  (b_q),
        .op (op_q),
        .y  (alu_y)
    );

    always_comb begin
        r_d = r_q;
        case (int'(stage_q))
            STG_A_HI:   r_d.a     = {nib_in, a_q[NW-1:0]};
            STG_A_LO:   r_d.a     = {a_q[DW-1:NW], nib_in};
            STG_A_NEG:  r_d.a     = a_neg;
            STG_SHOW_A: r_d.shown = a_q;
            STG_OPCODE: r_d.op    = nib_in;
            STG_B_HI:   r_d.b     = {nib_in, b_q[NW-1:0]};
            STG_B_LO:   r_d.b     = {b_q[DW-1:NW], nib_in};
            STG_B_NEG:  r_d.b     = b_neg;
            STG_SHOW_Y: r_d.shown = alu_y;
            default:    r_d       = r_q;
        endcase
        if (rst) begin
            r_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

endmodule

// File: rtl/nsa_checker.sv
module nsa_checker
    import nsa_pkg::*;
#(
    parameter int NW = 4,
    localparam int DW = 2 * NW,
    localparam int SW = $clog2(NUM_STAGES + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic [NW-1:0] nib_in,
    input logic [DW-1:0] result_out,
    input logic [SW-1:0] stage_q,
    input logic [DW-1:0] a_q,
    input logic [DW-1:0] b_q,
    input logic [NW-1:0] op_q
);

    logic rst_d = 1'b1;

    always_ff @(posedge clk) begin
        rst_d <= rst;
    end

    // R1: state right after a reset edge
    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        rst_d |-> (int'(stage_q) == STG_A_HI && a_q == '0 && b_q == '0
                   && op_q == '0 && result_out == '0));

    // R2: forward step and wrap
    assert_stage_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!rst_d && int'(stage_q) < NUM_STAGES) |=> (stage_q == $past(stage_q) + SW'(1)));

    assert_stage_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (!rst_d && int'(stage_q) == NUM_STAGES) |=> (int'(stage_q) == STG_A_HI));

    // R4: negation only on the request pattern
    assert_neg_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (int'(stage_q) == STG_A_NEG && !(nib_in[2] && nib_in[1])) |=> $stable(a_q));

    assert_neg_apply_R4: assert property (@(posedge clk) disable iff (rst)
        (int'(stage_q) == STG_B_NEG && nib_in[2] && nib_in[1]) |=> (DW'(b_q + $past(b_q)) == '0));

    // R5: opcode capture
    assert_op_capture_R5: assert property (@(posedge clk) disable iff (rst)
        (int'(stage_q) == STG_OPCODE) |=> (op_q == $past(nib_in)));

    // R10: zero divisor
    assert_div_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (int'(stage_q) == STG_SHOW_Y && op_q == NW'(OP_DIV) && b_q == '0) |=> (result_out == '1));

    // R12: output holds outside the display stages
    assert_out_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (!rst_d && int'(stage_q) != STG_SHOW_A && int'(stage_q) != STG_SHOW_Y) |=> $stable(result_out));

endmodule

bind nibble_step_alu nsa_checker #(.NW(NW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .nib_in     (nib_in),
    .result_out (result_out),
    .stage_q    (stage_q),
    .a_q        (a_q),
    .b_q        (b_q),
    .op_q       (op_q)
);

// File: tb/nibble_step_alu_test.sv
module nibble_step_alu_test;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] nib = 4'h0;
    logic [7:0] res;

    always #2.5 clk = ~clk;

    nibble_step_alu uut (
        .clk        (clk),
        .rst        (rst),
        .nib_in     (nib),
        .result_out (res)
    );

    typedef struct {
        int         at;
        logic [7:0] val;
        string      req;
    } item_t;

    item_t      sb_q[$];
    item_t      it;
    int         cyc    = 0;
    int         checks = 0;
    int         fails  = 0;
    bit         done   = 1'b0;
    logic [7:0] shown  = 8'h00;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every item due in this cycle.
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].at == cyc) begin
            it = sb_q.pop_front();
            checks++;
            if (res !== it.val) begin
                fails++;
                $display("FAIL %s: result_out=%h expected %h (cycle %0d)", it.req, res, it.val, cyc);
            end
        end
    end

    function automatic logic [7:0] model(input logic [7:0] a, input logic [7:0] b, input logic [3:0] op);
        int sa = $signed(a);
        int sb = $signed(b);
        int r;
        case (op)
            4'd0: r = sa + sb;
            4'd1: r = sa - sb;
            4'd2: r = sa * sb;
            4'd3: begin
                if (sb == 0) return 8'hFF;
                r = sa / sb;
            end
            default: r = 0;
        endcase
        return r[7:0];
    endfunction

    // Driver: set the input at a falling edge, expect the value after the next rising edge.
    task automatic step(input logic [3:0] s, input logic [7:0] exp, input string req);
        nib = s;
        sb_q.push_back('{cyc + 1, exp, req});
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        nib = 4'hF;
        sb_q.push_back('{cyc + 1, 8'h00, "R1"});
        @(negedge clk);
        rst = 1'b0;
        shown = 8'h00;
    endtask

    task automatic run(input logic [3:0] ahi, input logic [3:0] alo, input logic [3:0] na,
                       input logic [3:0] op, input logic [3:0] bhi, input logic [3:0] blo,
                       input logic [3:0] nb, input string req);
        logic [7:0] a = {ahi, alo};
        logic [7:0] b = {bhi, blo};
        logic [7:0] y;
        if (na[2] && na[1]) a = 8'd0 - a;
        if (nb[2] && nb[1]) b = 8'd0 - b;
        y = model(a, b, op);
        step(ahi, shown, "R12 hold in stage 1");
        step(alo, shown, "R12 hold in stage 2");
        step(na,  shown, "R12 hold in stage 3");
        step(4'h0, a,    "R3/R4 operand A shown");
        step(op,  a,     "R12 hold in stage 5");
        step(bhi, a,     "R5/R12 hold in stage 6");
        step(blo, a,     "R5/R12 hold in stage 7");
        step(nb,  a,     "R12 hold in stage 8");
        step(4'h0, y,    req);
        shown = y;
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        do_reset();                                  // R1 reset state
        run(4'h1, 4'h2, 4'h0, 4'h0, 4'h3, 4'h4, 4'h0, "R6 add 12+34");
        run(4'h7, 4'hF, 4'h0, 4'h0, 4'h0, 4'h1, 4'h0, "R6 add wrap 7F+01");
        run(4'h0, 4'h5, 4'h0, 4'h1, 4'h0, 4'h9, 4'h0, "R7 sub 05-09");
        run(4'h0, 4'hA, 4'h0, 4'h1, 4'h0, 4'h3, 4'h6, "R4 B negated by 0110, R7");
        run(4'h0, 4'h7, 4'h6, 4'h2, 4'h0, 4'h3, 4'h0, "R8 mul -7*3");
        run(4'h1, 4'h0, 4'h0, 4'h2, 4'h1, 4'h0, 4'h0, "R8 mul 10*10 low bits");
        run(4'h0, 4'hF, 4'h0, 4'h2, 4'h1, 4'h1, 4'h0, "R8 mul 0F*11");
        run(4'h0, 4'h7, 4'hF, 4'h3, 4'h0, 4'h2, 4'h0, "R9 div -7/2 toward zero");
        run(4'h6, 4'h4, 4'h6, 4'h3, 4'h0, 4'h5, 4'hE, "R9 div -100/-5");
        run(4'h8, 4'h0, 4'h0, 4'h3, 4'h0, 4'h1, 4'h6, "R9 div -128/-1");
        run(4'h3, 4'h3, 4'h0, 4'h3, 4'h0, 4'h0, 4'h0, "R10 div by zero");
        run(4'h0, 4'h0, 4'h0, 4'h3, 4'h0, 4'h0, 4'h0, "R10 zero by zero");
        run(4'h2, 4'hA, 4'h0, 4'h4, 4'h1, 4'h1, 4'h0, "R11 opcode 0100");
        run(4'h2, 4'hA, 4'h0, 4'hF, 4'h1, 4'h1, 4'h0, "R11 opcode 1111");
        run(4'h0, 4'h3, 4'h4, 4'h0, 4'h0, 4'h2, 4'h2, "R4 patterns 0100/0010 keep");
        run(4'h0, 4'h3, 4'h9, 4'h0, 4'h0, 4'h2, 4'h8, "R4 patterns 1001/1000 keep");
        run(4'h0, 4'h2, 4'h0, 4'h1, 4'hF, 4'hF, 4'h0, "R5 opcode and B nibbles");
        // Partial sequence, then reset in stage 5
        step(4'h5, shown, "R12 hold before reset");
        step(4'h5, shown, "R12 hold before reset");
        step(4'h0, shown, "R12 hold before reset");
        step(4'h0, 8'h55, "R3 operand A 55 shown");
        shown = 8'h55;
        do_reset();                                  // R1 mid-sequence
        run(4'h0, 4'h1, 4'h0, 4'h0, 4'h0, 4'h1, 4'h0, "R2 restart at stage 1 after reset");
        @(negedge clk);
        @(negedge clk);
        if (sb_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL R2: %0d items left unchecked, expected 0", sb_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule